// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply-Accumulate Grid

The block is a square grid of processing elements that multiplies a stream of activation vectors by a resident weight matrix. Each element keeps one signed weight. Activations move left to right along the rows, and partial sums move top to bottom along the columns. An element multiplies the activation arriving from its left by its own weight and adds the product to the sum arriving from above. It then passes the activation to the right and the new sum downward. Each column's finished dot product leaves at the bottom edge, with a valid flag.

Every element has a shadow weight register that software-side logic fills through a write port while the grid keeps computing. A swap strobe starts a diagonal token wave that sweeps through the grid together with the data. Each element moves its staged weight into use only when the token reaches it. Vectors already inside the grid therefore finish with the old weight set, later vectors use the new set, and the stream never pauses. Multiply-accumulates are always performed densely, so zero operands still pass through the full datapath.

Top module: `wsmac_array`

## Requirements
- R1: After synchronous reset, every `sum_vld` bit is 0 and all in-use, staged and shadow weights are zero. A vector streamed before any swap therefore gives a valid all-zero result.
- R2: For a vector `a`, column `c` delivers the signed 32-bit sum over rows `r` of `a[r] * W[r][c]`. Activations and weights are signed two's-complement 8-bit values.
- R3: Row `r` of a vector is presented `r` cycles after row 0. Column `c` result is visible after `DIM + c` rising edges, counted from the edge that samples row 0, so the last column appears after `2*DIM-1` edges. One new vector can enter every cycle.
- R4: `sum_vld[c]` is 1 only for a vector whose elements were all flagged valid on `act_vld`. A vector with any invalid row produces no valid output in any column.
- R5: A write (`wr_en`, `wr_row`, `wr_col`, `wr_data`) changes only the shadow weight of element (`wr_row`, `wr_col`). Results do not change until a swap is accepted.
- R6: An accepted swap applies to the vector whose row 0 is presented in the same cycle as `swap`, and to all later vectors. Vectors presented earlier complete with the previous weight set, and the stream does not stall.
- R7: A swap captures the shadow weights as they stood before that cycle. A write issued in the same cycle as the swap waits for the next swap.
- R8: A `swap` request made in any of the `2*DIM-2` cycles after an accepted swap is ignored. The weight set in use stays the same.
- R9: Zero-valued weights or activations are not skipped. They give valid results with the same latency as nonzero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Shadow weight write enable |
| wr_row | input | $clog2(DIM) | Row of the element to write |
| wr_col | input | $clog2(DIM) | Column of the element to write |
| wr_data | input | 8 | Signed weight value written into the shadow register |
| swap | input | 1 | Request to start using the shadow weight set |
| act_in | input | DIM x 8 | Skewed activation per row, row `r` in slice `r` |
| act_vld | input | DIM | Valid flag per activation row |
| sum_out | output | DIM x 32 | Signed column dot products, column `c` in slice `c` |
| sum_vld | output | DIM | Valid flag per column result |

## Verification
The grid is tried with ascending mixed-sign vectors, with vectors whose rows all hold -128, all hold 127 or all hold zero, and with weight sets that contain the signed extremes and zeros. Together these separate correct sign extension and dense accumulation from truncated or skipped arithmetic. A second weight set is loaded while vectors stream back to back, and it is swapped in mid-stream. The results on either side of the swap show whether the token wave aligns with the data, or whether any element changes weight too early or too late. Further patterns cover a swap request inside the hold-off window, a write in the same cycle as a swap, and vectors with one invalid row. Each of these can be told apart only by how it changes later column values or the valid flags.

// File: rtl/wsmac_pkg.sv
package wsmac_pkg;

    parameter int ACT_W = 8;
    parameter int W_W   = 8;
    parameter int SUM_W = 32;

    typedef logic signed [ACT_W-1:0] act_t;
    typedef logic signed [W_W-1:0]   wgt_t;
    typedef logic signed [SUM_W-1:0] acc_t;

    // Activation travelling along a row, with its valid flag and swap token
    typedef struct packed {
        logic vld;
        logic tok;
        act_t act;
    } lane_t;

    // Partial sum travelling down a column
    typedef struct packed {
        logic vld;
        acc_t sum;
    } psum_t;

    function automatic acc_t mac_term(input wgt_t w, input act_t a);
        acc_t wx;
        acc_t ax;
        wx = acc_t'(w);
        ax = acc_t'(a);
        return wx * ax;
    endfunction

endpackage

// File: rtl/wsmac_delay.sv
module wsmac_delay #(
    parameter int DEPTH = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_shift
            logic [DEPTH-1:0] sr;
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= DEPTH'({sr, d});
            end
            assign q = sr[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/wsmac_swapctl.sv
module wsmac_swapctl #(
    parameter int HOLD = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic acc
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt;

    // A request is taken only once the previous token wave has left the grid
    assign acc = req && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (acc)        cnt <= CW'(HOLD);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // R8: two swaps are never accepted on consecutive cycles
    a_r8_swap_spacing: assert property (@(posedge clk) disable iff (rst)
        acc |=> !acc);
endmodule

// File: rtl/wsmac_pe.sv
module wsmac_pe
    import wsmac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_hit,
    input  wgt_t  wr_data,
    input  logic  snap,
    input  lane_t a_in,
    input  psum_t p_in,
    output lane_t a_out,
    output psum_t p_out
);
    wgt_t shadow_q;
    wgt_t staged_q;
    wgt_t live_q;
    wgt_t w_use;

    // The token marks the first operand that must see the staged weight.
    // Only the top-left element can meet the token on the snapshot edge itself.
    always_comb begin
        if (a_in.tok) w_use = snap ? shadow_q : staged_q;
        else          w_use = live_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            staged_q <= '0;
            live_q   <= '0;
            a_out    <= '0;
            p_out    <= '0;
        end else begin
            if (wr_hit)   shadow_q <= wr_data;
            if (snap)     staged_q <= shadow_q;
            if (a_in.tok) live_q   <= w_use;
            a_out     <= a_in;
            p_out.vld <= p_in.vld & a_in.vld;
            p_out.sum <= p_in.sum + mac_term(w_use, a_in.act);
        end
    end

    // R5: the weight in use changes only when the swap token passes
    a_r5_weight_hold: assert property (@(posedge clk) disable iff (rst)
        !a_in.tok |=> $stable(live_q));

    // R6: a passing token installs the weight captured at the swap
    a_r6_token_load: assert property (@(posedge clk) disable iff (rst)
        (a_in.tok && !snap) |=> (live_q == $past(staged_q)));

    // R4: a valid partial sum needs a valid activation in this element
    a_r4_sum_valid: assert property (@(posedge clk) disable iff (rst)
        p_out.vld |-> $past(a_in.vld));
endmodule

// File: rtl/wsmac_array.sv
module wsmac_array
    import wsmac_pkg::*;
#(
    parameter int DIM = 4,
    localparam int IW = $clog2(DIM)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IW-1:0]               wr_row,
    input  logic [IW-1:0]               wr_col,
    input  logic [W_W-1:0]              wr_data,
    input  logic                        swap,
    input  logic [DIM-1:0][ACT_W-1:0]   act_in,
    input  logic [DIM-1:0]              act_vld,
    output logic [DIM-1:0][SUM_W-1:0]   sum_out,
    output logic [DIM-1:0]              sum_vld
);
    localparam int HOLD = 2 * DIM - 2;

    lane_t lane [DIM][DIM+1];
    psum_t ps   [DIM+1][DIM];
    logic  tok  [DIM];
    logic  swap_acc;

    wsmac_swapctl #(.HOLD(HOLD)) u_swapctl (
        .clk (clk),
        .rst (rst),
        .req (swap),
        .acc (swap_acc)
    );

    generate
        for (genvar r = 0; r < DIM; r++) begin : g_row_edge
            // Token enters row r with the same skew as the activations
            wsmac_delay #(.DEPTH(r)) u_tok_skew (
                .clk (clk),
                .rst (rst),
                .d   (swap_acc),
                .q   (tok[r])
            );
            assign lane[r][0] = '{vld: act_vld[r], tok: tok[r], act: act_t'(act_in[r])};
        end

        for (genvar c = 0; c < DIM; c++) begin : g_col_edge
            assign ps[0][c]   = '{vld: 1'b1, sum: '0};
            assign sum_out[c] = ps[DIM][c].sum;
            assign sum_vld[c] = ps[DIM][c].vld;
        end

        for (genvar r = 0; r < DIM; r++) begin : g_r
            for (genvar c = 0; c < DIM; c++) begin : g_c
                wsmac_pe u_pe (
                    .clk     (clk),
                    .rst     (rst),
                    .wr_hit  (wr_en && (wr_row == IW'(r)) && (wr_col == IW'(c))),
                    .wr_data (wgt_t'(wr_data)),
                    .snap    (swap_acc),
                    .a_in    (lane[r][c]),
                    .p_in    (ps[r][c]),
                    .a_out   (lane[r][c+1]),
                    .p_out   (ps[r+1][c])
                );
            end
        end
    endgenerate

    // R4: column 0 completes on the edge that takes the last row, which must be valid
    a_r4_full_column: assert property (@(posedge clk) disable iff (rst)
        sum_vld[0] |-> $past(act_vld[DIM-1]));

    // R8: a request inside the hold-off window does not snapshot the shadow bank
    a_r8_ignore_busy: assert property (@(posedge clk) disable iff (rst)
        swap_acc |=> !swap_acc);
endmodule

// File: tb/wsmac_array_test.sv
module wsmac_array_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIM  = 4;
    localparam int IW   = $clog2(DIM);
    localparam int HOLD = 2 * DIM - 2;

    logic                    clk;
    logic                    rst;
    logic                    wr_en;
    logic [IW-1:0]           wr_row;
    logic [IW-1:0]           wr_col;
    logic [7:0]              wr_data;
    logic                    swap;
    logic [DIM-1:0][7:0]     act_in;
    logic [DIM-1:0]          act_vld;
    logic [DIM-1:0][31:0]    sum_out;
    logic [DIM-1:0]          sum_vld;

    wsmac_array #(.DIM(DIM)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
        .wr_data(wr_data), .swap(swap), .act_in(act_in), .act_vld(act_vld),
        .sum_out(sum_out), .sum_vld(sum_vld)
    );

    typedef struct {
        logic signed [31:0] v;
        int                 due;
    } exp_t;

    exp_t               expq [DIM][$];
    logic signed [7:0]  shadow_m [DIM][DIM];
    logic signed [7:0]  cur_m    [DIM][DIM];
    logic [DIM-1:0][7:0] hist_a [DIM];
    logic [DIM-1:0]     hist_v [DIM];
    int                 busy_m;
    int                 step_no;
    int                 n_chk;
    int                 n_fail;
    string              phase;

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got hang, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    function automatic logic [DIM-1:0][7:0] vec(input int i);
        logic [DIM-1:0][7:0] v;
        for (int r = 0; r < DIM; r++) begin
            if (i == 3)      v[r] = 8'h80;   // all -128
            else if (i == 4) v[r] = 8'h00;   // all zero (R9)
            else if (i == 5) v[r] = 8'h7f;   // all 127
            else             v[r] = 8'(i * 37 + r * 29 - 70);
        end
        return v;
    endfunction

    function automatic logic [7:0] w1(input int r, input int c);
        if (r == 0 && c == 0) return 8'h80;
        if (r == 3 && c == 3) return 8'h7f;
        if (r == 1 && c == 2) return 8'h00;
        return 8'(r * 5 - c * 9 + 3);
    endfunction

    function automatic logic [7:0] w2(input int r, input int c);
        if (r == 2 && c == 1) return 8'h00;
        return 8'(c * 6 - r * 7 - 2);
    endfunction

    // Monitor: compare outputs seen after the last edge with the scoreboard
    task automatic monitor();
        for (int c = 0; c < DIM; c++) begin
            while (expq[c].size() > 0 && expq[c][0].due < step_no) begin
                n_chk++;
                n_fail++;
                $display("FAIL [%s] R3 col %0d missed result: got none, expected sum=%0d at step %0d",
                         phase, c, expq[c][0].v, expq[c][0].due);
                void'(expq[c].pop_front());
            end
            if (expq[c].size() > 0 && expq[c][0].due == step_no) begin
                n_chk++;
                if (sum_vld[c] !== 1'b1 || $signed(sum_out[c]) !== expq[c][0].v) begin
                    n_fail++;
                    $display("FAIL [%s] R2/R3 col %0d step %0d: got vld=%0b sum=%0d, expected vld=1 sum=%0d",
                             phase, c, step_no, sum_vld[c], $signed(sum_out[c]), expq[c][0].v);
                end
                void'(expq[c].pop_front());
            end else if (sum_vld[c] !== 1'b0) begin
                n_chk++;
                n_fail++;
                $display("FAIL [%s] R4 col %0d step %0d: got vld=%0b sum=%0d, expected vld=0",
                         phase, c, step_no, sum_vld[c], $signed(sum_out[c]));
            end
        end
    endtask

    // Driver: one cycle of stimulus; the scoreboard entry is computed from the model
    task automatic step(input logic [DIM-1:0][7:0] a, input logic [DIM-1:0] vm,
                        input logic sw, input logic we, input int wr, input int wc,
                        input logic [7:0] wd);
        @(negedge clk);
        step_no++;
        monitor();
        // R8 hold-off and R7 snapshot-before-write ordering
        if (busy_m > 0) begin
            busy_m--;
        end else if (sw) begin
            for (int r = 0; r < DIM; r++)
                for (int c = 0; c < DIM; c++) cur_m[r][c] = shadow_m[r][c];
            busy_m = HOLD;
        end
        if (we) shadow_m[wr][wc] = signed'(wd);
        if (&vm) begin
            for (int c = 0; c < DIM; c++) begin
                int   s;
                exp_t e;
                s = 0;
                for (int r = 0; r < DIM; r++)
                    s += int'(cur_m[r][c]) * int'(signed'(a[r]));
                e.v   = 32'(s);
                e.due = step_no + DIM + c;
                expq[c].push_back(e);
            end
        end
        for (int d = DIM - 1; d > 0; d--) begin
            hist_a[d] = hist_a[d-1];
            hist_v[d] = hist_v[d-1];
        end
        hist_a[0] = a;
        hist_v[0] = vm;
        for (int r = 0; r < DIM; r++) begin
            act_in[r]  = hist_a[r][r];
            act_vld[r] = hist_v[r][r];
        end
        swap    = sw;
        wr_en   = we;
        wr_row  = IW'(wr);
        wr_col  = IW'(wc);
        wr_data = wd;
    endtask

    task automatic feed(input int i, input logic sw);
        step(vec(i), '1, sw, 1'b0, 0, 0, 8'h00);
    endtask

    initial begin
        n_chk = 0; n_fail = 0; step_no = 0; busy_m = 0;
        for (int r = 0; r < DIM; r++) begin
            hist_a[r] = '0;
            hist_v[r] = '0;
            for (int c = 0; c < DIM; c++) begin
                shadow_m[r][c] = '0;
                cur_m[r][c]    = '0;
            end
        end
        rst = 1'b1; wr_en = 1'b0; wr_row = '0; wr_col = '0; wr_data = '0;
        swap = 1'b0; act_in = '0; act_vld = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: valid flags low straight out of reset
        phase = "R1 reset";
        n_chk++;
        if (sum_vld !== '0) begin
            n_fail++;
            $display("FAIL [R1] reset valid: got %b, expected 0000", sum_vld);
        end

        // R1: no swap yet, weights are zero -> valid zero result
        phase = "R1 zero weights";
        feed(0, 1'b0);

        // R5: load first set into the shadow bank while idle
        phase = "R5 shadow load";
        for (int i = 0; i < DIM * DIM; i++)
            step('0, '0, 1'b0, 1'b1, i / DIM, i % DIM, w1(i / DIM, i % DIM));

        // R6: swap with the first vector; R2 R9 mixed, extreme and zero operands
        phase = "R6 first swap";
        feed(1, 1'b1);
        phase = "R2 R9 stream";
        for (int i = 2; i < 10; i++) feed(i, 1'b0);

        // R5 R4: background load of the second set, some vectors with an invalid row
        phase = "R4 R5 background load";
        for (int i = 0; i < DIM * DIM; i++)
            step(vec(10 + i), (i % 5 == 2) ? 4'b1011 : 4'b1111, 1'b0, 1'b1,
                 i / DIM, i % DIM, w2(i / DIM, i % DIM));

        // R6: swap in the middle of a back-to-back stream
        phase = "R6 swap mid-stream";
        feed(30, 1'b1);

        // R8: change the shadow, then request swaps inside the hold-off window
        phase = "R8 hold-off";
        step(vec(31), '1, 1'b0, 1'b1, 0, 0, 8'd55);
        feed(32, 1'b0);
        feed(33, 1'b1);
        feed(34, 1'b0);
        feed(35, 1'b1);
        feed(36, 1'b0);

        // R7: swap together with a write; the write waits for a later swap
        phase = "R7 swap with write";
        step(vec(37), '1, 1'b1, 1'b1, 1, 1, 8'hf9);
        phase = "R5 R7 after swap";
        for (int i = 38; i < 44; i++) feed(i, 1'b0);

        // R3: drain; each result must land exactly on its due step
        phase = "R3 drain";
        for (int i = 0; i < 3 * DIM; i++) step('0, '0, 1'b0, 1'b0, 0, 0, 8'h00);

        for (int c = 0; c < DIM; c++) begin
            n_chk++;
            if (expq[c].size() != 0) begin
                n_fail++;
                $display("FAIL [R3] col %0d leftover: got %0d pending, expected 0", c, expq[c].size());
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule